// File: doc/BRIEF.md
# Three-Stage Forwarding Integer Pipeline

This block is a small in-order integer core built from three stages: a fetch stage that reads one 32-bit word per cycle from its own instruction port, a decode stage that splits the word into fields and reads two register operands, and an execute stage that computes the result and writes it into the register file in the same cycle. There is no data memory and no control flow; the program counter simply walks the instruction port in steps of four.

When the instruction in decode reads a register that the instruction in execute is about to write, the value in the register file is stale. A hazard unit detects this. Depending on a configuration input it either steers the execute result straight into the dependent operand, costing no cycle, or holds fetch and decode for one cycle and sends a bubble into execute. A debug port lets the environment preload and inspect registers, and a retire strobe reports each completed instruction for scoreboarding.

Top module: `pipe3_core`

## Requirements
- R1: While `rst` is high and on the first clock edge after it falls, `imem_addr` is 0 and `retire_valid` is 0; the instruction at address 0 retires in the second cycle after reset release.
- R2: An instruction is executed only when bits 31:30 equal 2'b10 and bit 13 is 0; the destination is bits 29:25, the opcode bits 24:19, the first source bits 18:14 and the second source bits 4:0. Any other word is a no-op that writes no register and raises no retire.
- R3: Opcode 6'b000000 writes first source plus second source; opcode 6'b000100 writes first source minus second source; both wrap modulo 2^32. Every other opcode is a no-op.
- R4: `imem_addr` shows the program counter, which advances by 4 on every cycle without a stall; with no stall, instruction k (address 4k) retires exactly k+2 cycles after reset release.
- R5: With `fwd_en` high, an instruction that reads the destination of the instruction just ahead of it gets the new value and loses no cycle.
- R6: With `fwd_en` low, such a dependent instruction is held for exactly one cycle: `imem_addr` is frozen, no retire occurs in the following cycle, program order is kept and the result is correct.
- R7: Register 0 reads as zero on every port, a write to it is discarded, and an instruction reading register 0 never causes a forward or a stall.
- R8: `retire_valid` is high for one cycle per executed add or subtract, in program order, with `retire_rd` equal to its destination and `retire_data` equal to its computed result.
- R9: A `dbg_we` write stores `dbg_wdata` into register `dbg_addr` at the clock edge, and `dbg_rdata` shows the current contents of register `dbg_addr` without delay.
- R10: A dependency on an instruction two slots ahead (with one unrelated slot between) causes no stall in either mode and reads the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1: resolve conflicts by forwarding, 0: by a one-cycle stall |
| imem_addr | output | 32 | Byte address of the word being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dbg_we | input | 1 | Debug register write enable |
| dbg_addr | input | 5 | Debug register index for read and write |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Current contents of register `dbg_addr` |
| retire_valid | output | 1 | An add or subtract completes this cycle |
| retire_rd | output | 5 | Destination index of the completing instruction |
| retire_data | output | 32 | Result of the completing instruction |

## Verification
The assertions take for granted that `imem_rdata` is a combinational function of `imem_addr`, that `fwd_en` does not change while a program runs, and that debug writes never coincide with an execute-stage write. The stimulus keeps within this by preloading registers only while reset is held, choosing the hazard mode before reset is released, and serving instructions from a bench array that answers in the same cycle and returns all-zero words (no-ops) past the program's end.

// File: rtl/pipe3_pkg.sv
`timescale 1ns/1ps
package pipe3_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RAW    = $clog2(NREG);
    localparam int IW     = 32;
    localparam int PC_INC = IW / 8;

    // field positions of the fixed three-register format
    localparam int F_FMT_HI = 31;
    localparam int F_FMT_LO = 30;
    localparam int F_RD_LO  = 25;
    localparam int F_OP_HI  = 24;
    localparam int F_OP_LO  = 19;
    localparam int F_RS1_LO = 14;
    localparam int F_IMM    = 13;
    localparam int F_RS2_LO = 0;

    localparam logic [1:0] FMT_ALU = 2'b10;
    localparam logic [5:0] OPC_ADD = 6'b000000;
    localparam logic [5:0] OPC_SUB = 6'b000100;

    typedef enum logic [1:0] {
        K_NOP = 2'd0,
        K_ADD = 2'd1,
        K_SUB = 2'd2
    } alu_kind_e;

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] word;
    } fetch_slot_t;

    typedef struct packed {
        alu_kind_e      kind;
        logic [RAW-1:0] rd;
        logic [RAW-1:0] rs1;
        logic [RAW-1:0] rs2;
    } decoded_t;

    typedef struct packed {
        alu_kind_e       kind;
        logic [RAW-1:0]  rd;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } exec_slot_t;

    function automatic decoded_t decode_word(input fetch_slot_t s);
        decoded_t d;
        d.rd   = s.word[F_RD_LO  +: RAW];
        d.rs1  = s.word[F_RS1_LO +: RAW];
        d.rs2  = s.word[F_RS2_LO +: RAW];
        d.kind = K_NOP;
        if (s.valid && s.word[F_FMT_HI:F_FMT_LO] == FMT_ALU && !s.word[F_IMM]) begin
            case (s.word[F_OP_HI:F_OP_LO])
                OPC_ADD: d.kind = K_ADD;
                OPC_SUB: d.kind = K_SUB;
                default: d.kind = K_NOP;
            endcase
        end
        return d;
    endfunction
endpackage

// File: rtl/pipe3_regfile.sv
`timescale 1ns/1ps
module pipe3_regfile
    import pipe3_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int N   = NREG,
    parameter int NRD = 3,
    localparam int AW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

    // R9: a write to a nonzero register is visible on the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/pipe3_hazard.sv
`timescale 1ns/1ps
module pipe3_hazard
    import pipe3_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = RAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fwd_en,
    input  logic            dec_uses,
    input  logic [AW-1:0]   dec_rs1,
    input  logic [AW-1:0]   dec_rs2,
    input  logic            ex_writes,
    input  logic [AW-1:0]   ex_rd,
    input  logic [W-1:0]    ex_result,
    input  logic [W-1:0]    rf_a,
    input  logic [W-1:0]    rf_b,
    output logic [W-1:0]    op_a,
    output logic [W-1:0]    op_b,
    output logic            stall
);
    logic [1:0][AW-1:0] src;
    logic [1:0][W-1:0]  rf_val;
    logic [1:0][W-1:0]  op_val;
    logic [1:0]         match;

    assign src    = {dec_rs2, dec_rs1};
    assign rf_val = {rf_b, rf_a};

    for (genvar s = 0; s < 2; s++) begin : g_src
        assign match[s]  = dec_uses && ex_writes && ex_rd != '0 && src[s] == ex_rd;
        assign op_val[s] = (match[s] && fwd_en) ? ex_result : rf_val[s];
    end

    assign op_a  = op_val[0];
    assign op_b  = op_val[1];
    assign stall = (|match) && !fwd_en;

    // R5: forwarding mode never loses a cycle
    p_fwd_no_stall_r5: assert property (@(posedge clk) disable iff (rst)
        fwd_en |-> !stall);
    // R6: a stall lasts exactly one cycle
    p_single_stall_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);
endmodule

// File: rtl/pipe3_alu.sv
`timescale 1ns/1ps
module pipe3_alu
    import pipe3_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_kind_e     kind,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  result
);
    always_comb begin
        case (kind)
            K_ADD:   result = a + b;
            K_SUB:   result = a - b;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/pipe3_core.sv
`timescale 1ns/1ps
module pipe3_core
    import pipe3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_en,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [IW-1:0]    imem_rdata,
    input  logic             dbg_we,
    input  logic [RAW-1:0]   dbg_addr,
    input  logic [XLEN-1:0]  dbg_wdata,
    output logic [XLEN-1:0]  dbg_rdata,
    output logic             retire_valid,
    output logic [RAW-1:0]   retire_rd,
    output logic [XLEN-1:0]  retire_data
);
    localparam int NRD = 3;

    logic [XLEN-1:0] pc_q;
    fetch_slot_t     ifid_q;
    exec_slot_t      idex_q;
    decoded_t        dec;

    logic [NRD-1:0][RAW-1:0]  rf_raddr;
    logic [NRD-1:0][XLEN-1:0] rf_rdata;
    logic            rf_we;
    logic [RAW-1:0]  rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    logic [XLEN-1:0] op_a, op_b, ex_result;
    logic            ex_writes, stall;

    // decode stage
    assign dec      = decode_word(ifid_q);
    assign rf_raddr = {dbg_addr, dec.rs2, dec.rs1};

    // execute stage
    assign ex_writes = (idex_q.kind != K_NOP);

    pipe3_alu u_alu (
        .kind   (idex_q.kind),
        .a      (idex_q.a),
        .b      (idex_q.b),
        .result (ex_result)
    );

    // single write port, debug preload takes precedence
    assign rf_we    = dbg_we || ex_writes;
    assign rf_waddr = dbg_we ? dbg_addr  : idex_q.rd;
    assign rf_wdata = dbg_we ? dbg_wdata : ex_result;

    pipe3_regfile #(.NRD(NRD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    pipe3_hazard u_hz (
        .clk       (clk),
        .rst       (rst),
        .fwd_en    (fwd_en),
        .dec_uses  (dec.kind != K_NOP),
        .dec_rs1   (dec.rs1),
        .dec_rs2   (dec.rs2),
        .ex_writes (ex_writes),
        .ex_rd     (idex_q.rd),
        .ex_result (ex_result),
        .rf_a      (rf_rdata[0]),
        .rf_b      (rf_rdata[1]),
        .op_a      (op_a),
        .op_b      (op_b),
        .stall     (stall)
    );

    // pipeline registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ifid_q <= '0;
            idex_q <= '0;
        end else if (stall) begin
            idex_q <= '0;
        end else begin
            pc_q         <= pc_q + XLEN'(PC_INC);
            ifid_q.valid <= 1'b1;
            ifid_q.word  <= imem_rdata;
            idex_q.kind  <= dec.kind;
            idex_q.rd    <= dec.rd;
            idex_q.a     <= op_a;
            idex_q.b     <= op_b;
        end
    end

    assign imem_addr    = pc_q;
    assign dbg_rdata    = rf_rdata[2];
    assign retire_valid = ex_writes;
    assign retire_rd    = idex_q.rd;
    assign retire_data  = ex_result;

    // R4: the fetch address steps by one word when no stall is pending
    p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
        !stall |=> imem_addr == $past(imem_addr) + XLEN'(PC_INC));
    // R6: fetch is frozen across a stall
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(imem_addr));
    // R6: the cycle after a stall carries a bubble in execute
    p_stall_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !retire_valid);
    // R1: nothing retires right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !retire_valid);
endmodule

// File: tb/pipe3_core_tb.sv
`timescale 1ns/1ps
module pipe3_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fwd_en = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        retire_valid;
    logic [4:0]  retire_rd;
    logic [31:0] retire_data;

    int checks = 0;
    int fails  = 0;

    logic [31:0] prog [64];
    logic [31:0] model_rf [32];

    int          exp_n;
    logic [4:0]  exp_rd  [16];
    logic [31:0] exp_dat [16];
    int          exp_cyc [16];

    always #10 clk = ~clk;

    assign imem_rdata = (imem_addr[31:8] == '0) ? prog[imem_addr[7:2]] : 32'h0;

    pipe3_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .fwd_en       (fwd_en),
        .imem_addr    (imem_addr),
        .imem_rdata   (imem_rdata),
        .dbg_we       (dbg_we),
        .dbg_addr     (dbg_addr),
        .dbg_wdata    (dbg_wdata),
        .dbg_rdata    (dbg_rdata),
        .retire_valid (retire_valid),
        .retire_rd    (retire_rd),
        .retire_data  (retire_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                       input logic [4:0] a, input logic [4:0] b);
        return {2'b10, rd, op, a, 1'b0, 8'h00, b};
    endfunction

    // hold reset, pick mode, clear program and model
    task automatic begin_case(input bit fwd);
        @(negedge clk);
        rst    = 1'b1;
        fwd_en = fwd;
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
        @(negedge clk);
    endtask

    task automatic preload(input int idx, input logic [31:0] val);
        dbg_we    = 1'b1;
        dbg_addr  = 5'(idx);
        dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
        if (idx != 0) model_rf[idx] = val;
    endtask

    // build expected retire list from the requirements, then run
    task automatic run_prog(input int n, input string req);
        int shift = 0;
        bit pv = 0;
        logic [4:0] prd = '0;
        int got = 0;
        exp_n = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = prog[i];
            bit ok = (w[31:30] == 2'b10) && !w[13] &&
                     (w[24:19] == 6'b000000 || w[24:19] == 6'b000100);
            logic [4:0] rd = w[29:25];
            logic [4:0] a  = w[18:14];
            logic [4:0] b  = w[4:0];
            if (ok) begin
                logic [31:0] va = (a == 0) ? 32'h0 : model_rf[a];
                logic [31:0] vb = (b == 0) ? 32'h0 : model_rf[b];
                if (!fwd_en && pv && prd != 0 && (a == prd || b == prd)) shift++;
                exp_rd[exp_n]  = rd;
                exp_dat[exp_n] = (w[24:19] == 6'b000000) ? va + vb : va - vb;
                exp_cyc[exp_n] = i + 2 + shift;
                if (rd != 0) model_rf[rd] = exp_dat[exp_n];
                exp_n++;
            end
            pv  = ok;
            prd = rd;
        end
        rst = 1'b0;
        for (int c = 1; c <= 2 * n + 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (retire_valid) begin
                if (got < exp_n) begin
                    chk(req, "R8 retire rd",    32'(retire_rd), 32'(exp_rd[got]));
                    chk(req, "R8 retire data",  retire_data,    exp_dat[got]);
                    chk(req, "R4 retire cycle", 32'(c),         32'(exp_cyc[got]));
                end
                got++;
            end
        end
        chk(req, "R8 retire count", 32'(got), 32'(exp_n));
        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r);
            #1;
            chk(req, "R9 final register", dbg_rdata, (r == 0) ? 32'h0 : model_rf[r]);
        end
    endtask

    task automatic t_reset_and_debug();
        begin_case(1'b1);
        chk("R1", "addr in reset", imem_addr, 32'h0);
        chk("R1", "retire in reset", 32'(retire_valid), 32'h0);
        preload(7, 32'hDEAD_BEEF);
        dbg_addr = 5'd7;
        #1;
        chk("R9", "debug readback", dbg_rdata, 32'hDEAD_BEEF);
        preload(0, 32'h5);
        dbg_addr = 5'd0;
        #1;
        chk("R7", "r0 after write", dbg_rdata, 32'h0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "retire after release", 32'(retire_valid), 32'h0);
        chk("R4", "addr after one edge", imem_addr, 32'h4);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R4", "addr after three edges", imem_addr, 32'hC);
        chk("R2", "zero word no retire", 32'(retire_valid), 32'h0);
    endtask

    task automatic t_independent();
        begin_case(1'b1);
        preload(2, 5); preload(3, 3); preload(5, 10); preload(6, 11);
        preload(8, 8); preload(9, 9);
        prog[0] = mk(6'b000000, 1, 2, 3);
        prog[1] = mk(6'b000000, 4, 5, 6);
        prog[2] = mk(6'b000000, 7, 8, 9);
        run_prog(3, "R3 independent");
    endtask

    task automatic t_chain(input bit fwd, input string req);
        begin_case(fwd);
        preload(2, 5); preload(3, 3); preload(6, 6);
        prog[0] = mk(6'b000000, 1, 2, 3);
        prog[1] = mk(6'b000000, 4, 1, 3);
        prog[2] = mk(6'b000000, 5, 6, 3);
        run_prog(3, req);
    endtask

    task automatic t_accumulate(input bit fwd, input string req);
        begin_case(fwd);
        preload(1, 1); preload(2, 32'h7FFF_FFFF); preload(3, 100);
        prog[0] = mk(6'b000000, 1, 1, 2);
        prog[1] = mk(6'b000000, 1, 1, 2);
        prog[2] = mk(6'b000000, 1, 2, 1);
        prog[3] = mk(6'b000100, 10, 1, 3);
        prog[4] = mk(6'b000100, 11, 3, 10);
        run_prog(5, req);
    endtask

    task automatic t_noops_and_r0();
        begin_case(1'b0);
        preload(2, 20); preload(3, 7); preload(12, 99);
        prog[0] = {2'b01, 5'd12, 6'b000000, 5'd2, 1'b0, 8'h0, 5'd3};
        prog[1] = mk(6'b000001, 12, 2, 3);
        prog[2] = mk(6'b000000, 12, 2, 3) | 32'h0000_2000;
        prog[3] = mk(6'b000000, 0, 2, 3);
        prog[4] = mk(6'b000000, 4, 0, 3);
        prog[5] = mk(6'b000000, 11, 2, 3);
        prog[6] = 32'h0;
        prog[7] = mk(6'b000000, 13, 11, 2);
        prog[8] = mk(6'b000100, 14, 3, 2);
        run_prog(9, "R2 R7 R10 noop/r0/gap");
    endtask

    initial begin
        for (int r = 0; r < 32; r++) model_rf[r] = 32'h0;
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
        t_reset_and_debug();
        t_independent();
        t_chain(1'b1, "R5 forward chain");
        t_chain(1'b0, "R6 stall chain");
        t_accumulate(1'b1, "R5 R3 accumulate fwd");
        t_accumulate(1'b0, "R6 R3 accumulate stall");
        t_noops_and_r0();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule